// File: doc/BRIEF.md
# Tagged Operand Reorder Queue

This block puts operand reads back into program order when the memory behind it can answer them out of order. Each accepted memory request gets a tag, which is also the index of an operand buffer register. The tag goes out with the request on `req_tag_o`. The same tag, together with the function code, is pushed into a short in-order function queue. Literal operands need no memory access. They still enter the queue, carrying their data, so they keep their place among the memory-based functions.

A memory reply names its tag. The reply data is written into that buffer, and the buffer is marked full. The queue head issues downstream through a valid/ready handshake once its operand is present. A literal head is always present. A memory head is present when its buffer is full, or when its reply arrives in the same cycle, in which case the reply data is forwarded straight to the output. On issue, the head's buffer is cleared and its tag goes back to the free pool.

Top module: `operand_reorder_q`

## Requirements
- R1: After reset, `out_valid_o` is 0, `req_ready_o` is 1, and `req_tag_o` shows tag 0.
- R2: Each accepted memory request (`req_lit_i`=0) receives the lowest-numbered tag that is not outstanding, presented on `req_tag_o` in the cycle the request is accepted.
- R3: The queue holds QDEPTH (default 6) entries. With QDEPTH entries pending and none issuing, `req_ready_o` is 0. Because NBUF >= QDEPTH, a free tag always exists while the queue has room.
- R4: Outputs issue in request order, whatever order the replies arrive in.
- R5: While the head is a memory entry whose reply has not arrived, `out_valid_o` stays 0, even if replies for later entries have arrived.
- R6: A reply whose tag matches the waiting head raises `out_valid_o` in that same cycle, and `out_data_o` carries the reply data.
- R7: A literal entry (`req_lit_i`=1) issues `req_lit_data_i` as its operand, takes no tag, and keeps its order relative to memory entries.
- R8: While `out_valid_o`=1 and `out_ready_i`=0, the head does not pop, and `out_func_o` and `out_data_o` hold their values.
- R9: A tag is freed when its entry issues and can then be allocated again.
- R10: `out_func_o` carries the function code given with the matching request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Request present |
| req_ready_o | output | 1 | Request accepted this cycle if valid |
| req_lit_i | input | 1 | 1 = literal operand, 0 = memory read |
| req_func_i | input | FUNC_W | Function code |
| req_lit_data_i | input | DATA_W | Literal operand value |
| req_tag_o | output | TAG_W | Tag for the memory request |
| rsp_valid_i | input | 1 | Memory reply present |
| rsp_tag_i | input | TAG_W | Tag of the reply |
| rsp_data_i | input | DATA_W | Reply operand |
| out_valid_o | output | 1 | Head function and operand available |
| out_ready_i | input | 1 | Consumer accepts |
| out_func_o | output | FUNC_W | Issued function code |
| out_data_o | output | DATA_W | Issued operand |

## Verification
The bench first sends replies in request order, which shows that the basic path and tag numbering work. It then sends replies in reverse and scrambled order. Only correct reordering and a correct head stall pass that pattern.

Literals mixed between memory requests show whether literals keep their place and whether they wrongly use up tags. A reply that arrives while the head is waiting separates same-cycle forwarding from a one-cycle-late issue. Filling the queue with no replies, and holding `out_ready_i` low, exercise the full-queue stall and the output hold.

// File: rtl/orq_pkg.sv
package orq_pkg;
  parameter int unsigned DEF_QDEPTH = 6;
  parameter int unsigned DEF_NBUF   = 8;
  parameter int unsigned DEF_FUNC_W = 8;
  parameter int unsigned DEF_DATA_W = 128;

  typedef enum logic [1:0] {
    SRC_NONE = 2'd0,
    SRC_LIT  = 2'd1,
    SRC_BUF  = 2'd2
  } op_src_e;
endpackage

// File: rtl/tag_pool.sv
module tag_pool #(
  parameter int unsigned NBUF = 8,
  localparam int unsigned TW = $clog2(NBUF)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          alloc_i,
  input  logic          free_i,
  input  logic [TW-1:0] free_tag_i,
  output logic          avail_o,
  output logic [TW-1:0] tag_o
);
  logic [NBUF-1:0] free_q;

  // lowest free index wins
  always_comb begin
    avail_o = 1'b0;
    tag_o   = '0;
    for (int i = NBUF - 1; i >= 0; i--) begin
      if (free_q[i]) begin
        avail_o = 1'b1;
        tag_o   = TW'(i);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) free_q <= '1;
    else begin
      if (alloc_i) free_q[tag_o] <= 1'b0;
      if (free_i)  free_q[free_tag_i] <= 1'b1;
    end
  end

  p_fresh_tag_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alloc_i |=> !free_q[$past(tag_o)]);
  p_no_double_free_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    free_i |-> !free_q[free_tag_i]);
endmodule

// File: rtl/func_fifo.sv
module func_fifo #(
  parameter int unsigned DEPTH = 6,
  parameter int unsigned W     = 8,
  localparam int unsigned PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         push_i,
  input  logic [W-1:0] din_i,
  input  logic         pop_i,
  output logic [W-1:0] dout_o,
  output logic         empty_o,
  output logic         full_o
);
  logic [W-1:0]  mem_q [DEPTH];
  logic [PW-1:0] wr_q, rd_q;
  logic [CW-1:0] cnt_q;

  function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign empty_o = (cnt_q == '0);
  assign full_o  = (cnt_q == CW'(DEPTH));
  assign dout_o  = mem_q[rd_q];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push_i) wr_q <= nxt(wr_q);
      if (pop_i)  rd_q <= nxt(rd_q);
      if (push_i && !pop_i)      cnt_q <= cnt_q + 1'b1;
      else if (!push_i && pop_i) cnt_q <= cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk_i) begin
    if (push_i) mem_q[wr_q] <= din_i;
  end

  p_no_overflow_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |-> !full_o);
  p_no_underflow_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> !empty_o);
  p_count_bound_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CW'(DEPTH));
endmodule

// File: rtl/operand_buf.sv
module operand_buf #(
  parameter int unsigned NBUF = 8,
  parameter int unsigned DW   = 128,
  localparam int unsigned TW  = $clog2(NBUF)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [TW-1:0] wr_tag_i,
  input  logic [DW-1:0] wr_data_i,
  input  logic [TW-1:0] rd_tag_i,
  input  logic          clr_i,
  output logic          hit_o,
  output logic [DW-1:0] rd_data_o
);
  logic [DW-1:0]   data_q [NBUF];
  logic [NBUF-1:0] full_q;
  logic            fwd;

  assign fwd       = wr_en_i && (wr_tag_i == rd_tag_i) && !full_q[rd_tag_i];
  assign hit_o     = full_q[rd_tag_i] || fwd;
  assign rd_data_o = fwd ? wr_data_i : data_q[rd_tag_i];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) full_q <= '0;
    else begin
      if (wr_en_i) full_q[wr_tag_i] <= 1'b1;
      if (clr_i)   full_q[rd_tag_i] <= 1'b0;  // clear wins on same-tag forward
    end
  end

  always_ff @(posedge clk_i) begin
    if (wr_en_i) data_q[wr_tag_i] <= wr_data_i;
  end

  p_stall_until_reply_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |-> (full_q[rd_tag_i] || (wr_en_i && wr_tag_i == rd_tag_i)));
  p_cleared_after_issue_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> !full_q[$past(rd_tag_i)]);
endmodule

// File: rtl/operand_reorder_q.sv
module operand_reorder_q
  import orq_pkg::*;
#(
  parameter int unsigned QDEPTH = DEF_QDEPTH,
  parameter int unsigned NBUF   = DEF_NBUF,
  parameter int unsigned FUNC_W = DEF_FUNC_W,
  parameter int unsigned DATA_W = DEF_DATA_W,
  localparam int unsigned TAG_W = $clog2(NBUF)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic              req_lit_i,
  input  logic [FUNC_W-1:0] req_func_i,
  input  logic [DATA_W-1:0] req_lit_data_i,
  output logic [TAG_W-1:0]  req_tag_o,
  input  logic              rsp_valid_i,
  input  logic [TAG_W-1:0]  rsp_tag_i,
  input  logic [DATA_W-1:0] rsp_data_i,
  output logic              out_valid_o,
  input  logic              out_ready_i,
  output logic [FUNC_W-1:0] out_func_o,
  output logic [DATA_W-1:0] out_data_o
);
  typedef struct packed {
    logic              lit;
    logic [FUNC_W-1:0] func;
    logic [TAG_W-1:0]  tag;
    logic [DATA_W-1:0] data;
  } entry_t;

  localparam int unsigned EW = $bits(entry_t);

  entry_t            wr_ent, head;
  logic [EW-1:0]     head_raw;
  logic              q_empty, q_full, push, pop, alloc, mem_pop;
  logic              pool_avail, buf_hit;
  logic [DATA_W-1:0] buf_data;
  op_src_e           src;

  assign req_ready_o = !q_full && (req_lit_i || pool_avail);
  assign push        = req_valid_i && req_ready_o;
  assign alloc       = push && !req_lit_i;

  always_comb begin
    wr_ent      = '0;
    wr_ent.lit  = req_lit_i;
    wr_ent.func = req_func_i;
    wr_ent.tag  = req_tag_o;
    wr_ent.data = req_lit_i ? req_lit_data_i : '0;
  end

  tag_pool #(.NBUF(NBUF)) u_pool (
    .clk_i, .rst_ni,
    .alloc_i    (alloc),
    .free_i     (mem_pop),
    .free_tag_i (head.tag),
    .avail_o    (pool_avail),
    .tag_o      (req_tag_o)
  );

  func_fifo #(.DEPTH(QDEPTH), .W(EW)) u_fifo (
    .clk_i, .rst_ni,
    .push_i  (push),
    .din_i   (wr_ent),
    .pop_i   (pop),
    .dout_o  (head_raw),
    .empty_o (q_empty),
    .full_o  (q_full)
  );
  assign head = entry_t'(head_raw);

  operand_buf #(.NBUF(NBUF), .DW(DATA_W)) u_buf (
    .clk_i, .rst_ni,
    .wr_en_i   (rsp_valid_i),
    .wr_tag_i  (rsp_tag_i),
    .wr_data_i (rsp_data_i),
    .rd_tag_i  (head.tag),
    .clr_i     (mem_pop),
    .hit_o     (buf_hit),
    .rd_data_o (buf_data)
  );

  always_comb begin
    if (q_empty)       src = SRC_NONE;
    else if (head.lit) src = SRC_LIT;
    else if (buf_hit)  src = SRC_BUF;
    else               src = SRC_NONE;
  end

  assign out_valid_o = (src != SRC_NONE);
  assign out_func_o  = head.func;
  assign out_data_o  = (src == SRC_LIT) ? head.data : buf_data;
  assign pop         = out_valid_o && out_ready_i;
  assign mem_pop     = pop && !head.lit;

  p_tag_for_every_slot_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !q_full |-> pool_avail);
  p_hold_valid_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !out_ready_i) |=> out_valid_o);
  p_hold_data_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !out_ready_i) |=> ($stable(out_func_o) && $stable(out_data_o)));
endmodule

// File: tb/operand_reorder_q_tb.sv
module operand_reorder_q_tb;
  localparam int CLK_P = 10;
  localparam int FW = 8;
  localparam int DW = 128;
  localparam int TW = 3;

  logic          clk = 0, rst_n = 0;
  logic          req_valid = 0, req_lit = 0;
  logic [FW-1:0] req_func = '0;
  logic [DW-1:0] req_lit_data = '0;
  logic          req_ready;
  logic [TW-1:0] req_tag;
  logic          rsp_valid = 0;
  logic [TW-1:0] rsp_tag = '0;
  logic [DW-1:0] rsp_data = '0;
  logic          out_valid, out_ready = 1;
  logic [FW-1:0] out_func;
  logic [DW-1:0] out_data;

  int total = 0, bad = 0;
  logic [FW+DW-1:0] sb[$];
  logic [DW-1:0]    tag_data [8];
  int seq = 0;
  logic          started = 0;

  always #(CLK_P/2) clk = ~clk;

  operand_reorder_q u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_lit_i(req_lit),
    .req_func_i(req_func), .req_lit_data_i(req_lit_data), .req_tag_o(req_tag),
    .rsp_valid_i(rsp_valid), .rsp_tag_i(rsp_tag), .rsp_data_i(rsp_data),
    .out_valid_o(out_valid), .out_ready_i(out_ready),
    .out_func_o(out_func), .out_data_o(out_data)
  );

  task automatic check(input bit ok, input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] mk(input int s);
    return {4{32'hA5C30000 ^ 32'(s * 32'h01010101)}};
  endfunction

  // inputs change at posedge+1; monitor samples at negedge
  task automatic send_mem(input logic [FW-1:0] f, output logic [TW-1:0] t);
    while (!req_ready) begin @(posedge clk); #1; end
    req_valid = 1; req_lit = 0; req_func = f;
    t = req_tag;
    seq++;
    tag_data[t] = mk(seq);
    sb.push_back({f, tag_data[t]});
    @(posedge clk); #1;
    req_valid = 0;
  endtask

  task automatic send_lit(input logic [FW-1:0] f, input logic [DW-1:0] d);
    while (!req_ready) begin @(posedge clk); #1; end
    req_valid = 1; req_lit = 1; req_func = f; req_lit_data = d;
    sb.push_back({f, d});
    @(posedge clk); #1;
    req_valid = 0; req_lit = 0;
  endtask

  task automatic reply(input logic [TW-1:0] t);
    rsp_valid = 1; rsp_tag = t; rsp_data = tag_data[t];
    @(posedge clk); #1;
    rsp_valid = 0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin @(posedge clk); #1; end
  endtask

  // scoreboard monitor: R4, R10
  always @(negedge clk) begin
    if (started && out_valid && out_ready) begin
      if (sb.size() == 0) check(0, "R4 unexpected issue", out_data, '0);
      else begin
        logic [FW+DW-1:0] e;
        e = sb.pop_front();
        check(out_func == e[FW+DW-1:DW], "R10 func", DW'(out_func), DW'(e[FW+DW-1:DW]));
        check(out_data == e[DW-1:0], "R4 order/data", out_data, e[DW-1:0]);
      end
    end
  end

  initial begin
    #(CLK_P * 100000);
    bad++;
    $display("FAIL watchdog act=hung exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [TW-1:0] t0, t1, t2, t3;
    logic [TW-1:0] tf [6];
    logic [DW-1:0] held;

    #(CLK_P * 3);
    @(negedge clk);
    check(out_valid == 0, "R1 valid", DW'(out_valid), 0);
    check(req_ready == 1, "R1 ready", DW'(req_ready), 1);
    check(req_tag == 0, "R1 tag", DW'(req_tag), 0);
    @(posedge clk); #1;
    rst_n = 1; started = 1;
    idle(1);

    // in-order replies, R2 tag numbering
    send_mem(8'h11, t0); send_mem(8'h12, t1); send_mem(8'h13, t2);
    check(t0 == 0 && t1 == 1 && t2 == 2, "R2 lowest tags", DW'({t0, t1, t2}), DW'({3'd0, 3'd1, 3'd2}));
    reply(t0); reply(t1); reply(t2);
    idle(2);

    // reverse/scrambled replies, R9 reuse, R5 stall
    send_mem(8'h21, t0); send_mem(8'h22, t1); send_mem(8'h23, t2); send_mem(8'h24, t3);
    check(t0 == 0 && t3 == 3, "R9 tags reused", DW'({t0, t3}), DW'({3'd0, 3'd3}));
    reply(t3); reply(t1);
    @(negedge clk);
    check(out_valid == 0, "R5 head stalls", DW'(out_valid), 0);
    @(posedge clk); #1;
    reply(t2); reply(t0);
    idle(3);
    check(sb.size() == 0, "R4 drained", DW'(sb.size()), 0);

    // literals mixed in, R7
    send_mem(8'h31, t0);
    send_lit(8'h32, {4{32'hDEADBEEF}});
    send_mem(8'h33, t1);
    check(t1 == t0 + 1, "R7 literal takes no tag", DW'(t1), DW'(t0 + 1));
    send_lit(8'h34, {4{32'h0BADF00D}});
    reply(t1);
    @(negedge clk);
    check(out_valid == 0, "R5 stall behind memory head", DW'(out_valid), 0);
    @(posedge clk); #1;
    reply(t0);
    idle(4);
    check(sb.size() == 0, "R7 literals issued in order", DW'(sb.size()), 0);

    // same-cycle forward, R6
    send_mem(8'h41, t0);
    idle(1);
    rsp_valid = 1; rsp_tag = t0; rsp_data = tag_data[t0];
    @(negedge clk);
    check(out_valid == 1, "R6 forward valid", DW'(out_valid), 1);
    check(out_data == tag_data[t0], "R6 forward data", out_data, tag_data[t0]);
    @(posedge clk); #1;
    rsp_valid = 0;
    idle(1);

    // full queue, R3
    for (int i = 0; i < 6; i++) send_mem(FW'(8'h50 + i), tf[i]);
    @(negedge clk);
    check(req_ready == 0, "R3 full stalls requests", DW'(req_ready), 0);
    @(posedge clk); #1;
    reply(tf[4]); reply(tf[0]); reply(tf[5]); reply(tf[2]); reply(tf[1]); reply(tf[3]);
    idle(8);
    check(sb.size() == 0, "R3 full queue drained", DW'(sb.size()), 0);

    // back-pressure, R8
    out_ready = 0;
    send_lit(8'h61, {4{32'h12345678}});
    @(negedge clk);
    check(out_valid == 1, "R8 valid with ready low", DW'(out_valid), 1);
    held = out_data;
    @(posedge clk); #1;
    idle(2);
    @(negedge clk);
    check(out_valid == 1 && out_data == held && out_func == 8'h61, "R8 held", out_data, held);
    @(posedge clk); #1;
    out_ready = 1;
    idle(2);
    check(sb.size() == 0, "R8 released", DW'(sb.size()), 0);
    @(negedge clk);
    check(req_tag == 0, "R9 all tags free", DW'(req_tag), 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule